// File: doc/BRIEF.md
# Interrupt-capable GPIO bank

This block is a bank of up to 32 general-purpose lines behind a small memory-mapped register port. Software sets each line, one bit per line in every register, to act as a plain input, a driven output, or an interrupt source. An interrupt source can be level-sensitive or edge-sensitive. Each source has its own polarity choice, and an edge source can also be set to react to transitions in both directions.

Pins are resynchronised by two flops before any use. Edge sources latch a pending bit that software clears by writing ones. Level sources show the live, polarity-adjusted pin state and are not latched. A per-line enable mask gates the status into a single combined interrupt request. The mask is cleared through one register and set through another, so software can change one line without a read-modify-write.

The bus is a single-cycle register port. A write takes effect at the clock edge while `bus_en` and `bus_wr` are high. Read data is combinational while `bus_en` is high and `bus_wr` is low, and is zero otherwise.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_o` are 0 and `irq_o` is 0.
- R2: The output latch at byte address 0x08 drives `pin_o`. A line drives `pin_oe` when its direction bit (0x04, 1 = output) is 1 and its mode bit (0x00, 1 = interrupt source) is 0.
- R3: A read of 0x0C returns, per line, the output latch bit if the direction bit is 1, and otherwise the pin value after the two-flop synchroniser.
- R4: A line with mode 1 and trigger bit 0 (0x24, 1 = edge) shows in the status register (0x10) the synchronised pin XOR its polarity bit (0x20, 1 = active low). The bit drops as soon as the pin goes inactive.
- R5: A line with mode 1 and trigger 1 latches a pending status bit. With polarity 0 a rising synchronised transition sets it, and with polarity 1 a falling one does.
- R6: With the both-edge bit (0x4C) at 1, an edge-mode line latches on rising and on falling transitions regardless of polarity.
- R7: Writing a 1 to a bit of 0x14 clears that latched bit, and writing 0 leaves it unchanged. An edge detected in the same cycle as the clear wins, and no latched bit drops without a clear write.
- R8: Writing 1s to 0x1C enables those lines. Writing 0s to 0x18 disables those lines, and 1s written there change nothing. 0x18 reads the enable set, and 0x14 and 0x1C read 0.
- R9: `irq_o` is 1 exactly when some line has both its status bit and its enable bit set.
- R10: The polarity, trigger, filter-enable (0x28) and both-edge registers read back what was written. Writes to 0x0C and 0x10 change nothing, and undecoded addresses read 0.
- R11: A line with mode bit 0 never shows status, whatever its trigger and polarity bits and pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_i | input | NLINES | Pin levels, asynchronous |
| pin_o | output | NLINES | Output latch to the pads |
| pin_oe | output | NLINES | Per-line drive enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Level sources are driven with active-high and active-low lines together, so that a polarity inversion or a latched level shows as a wrong status word. Edge sources are tested on three lines at once: one rising, one falling, and one set for both edges with polarity 1. Each pin is then moved up and down in turn, so that each wrong edge choice sets a bit that should stay clear. The mask is walked through no-effect writes and effective writes, and the irq output is checked after each one. This separates the clear-by-zero and set-by-one paths. The direction test mixes output and input lines in one word, so a readback that takes the pin instead of the latch is caught.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned DW     = 32;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_DIR, SEL_DOUT, SEL_DIN, SEL_STAT, SEL_CLR,
    SEL_MASK, SEL_UNMASK, SEL_POL, SEL_TRIG, SEL_FILT, SEL_BOTH
  } gpio_reg_e;

  function automatic gpio_reg_e f_decode(input logic [REG_AW-1:0] a);
    case (a)
      8'h00:   return SEL_MODE;
      8'h04:   return SEL_DIR;
      8'h08:   return SEL_DOUT;
      8'h0C:   return SEL_DIN;
      8'h10:   return SEL_STAT;
      8'h14:   return SEL_CLR;
      8'h18:   return SEL_MASK;
      8'h1C:   return SEL_UNMASK;
      8'h20:   return SEL_POL;
      8'h24:   return SEL_TRIG;
      8'h28:   return SEL_FILT;
      8'h4C:   return SEL_BOTH;
      default: return SEL_NONE;
    endcase
  endfunction

  // one line: did the sampled transition match the selected edge?
  function automatic logic f_edge_hit(input logic cur, input logic prev,
                                      input logic pol, input logic both);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (both) return rise | fall;
    return pol ? fall : rise;
  endfunction

  // one line: polarity-adjusted level
  function automatic logic f_level_hit(input logic cur, input logic pol);
    return cur ^ pol;
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] both_i,
  output logic [W-1:0] edge_hit_o,
  output logic [W-1:0] level_hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_line
    assign edge_hit_o[g]  = f_edge_hit(cur_i[g], prev_q[g], pol_i[g], both_i[g]);
    assign level_hit_o[g] = f_level_hit(cur_i[g], pol_i[g]);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_i,
  output logic [NLINES-1:0] pin_o,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq_o
);
  localparam int unsigned N = NLINES;

  logic [N-1:0] mode_q, dir_q, dout_q, mask_q, pol_q, trig_q, filt_q, both_q, pend_q;
  logic [N-1:0] line_sync, edge_hit, level_hit, evt_set, clr_req, status, irq_vec;
  logic [N-1:0] wdata_n;
  gpio_reg_e    sel;
  logic         wr_en, wr_clr, wr_mask, wr_unmask;

  assign sel       = f_decode(bus_addr);
  assign wr_en     = bus_en & bus_wr;
  assign wdata_n   = bus_wdata[N-1:0];
  assign wr_clr    = wr_en && (sel == SEL_CLR);
  assign wr_mask   = wr_en && (sel == SEL_MASK);
  assign wr_unmask = wr_en && (sel == SEL_UNMASK);

  gpio_sync2 #(.W(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(line_sync)
  );

  gpio_evt_detect #(.W(N)) u_evt (
    .clk(clk), .rst_n(rst_n), .cur_i(line_sync), .pol_i(pol_q),
    .both_i(both_q), .edge_hit_o(edge_hit), .level_hit_o(level_hit)
  );

  assign evt_set = mode_q & trig_q & edge_hit;
  assign clr_req = wr_clr ? wdata_n : '0;
  assign status  = mode_q & ((trig_q & pend_q) | (~trig_q & level_hit));
  assign irq_vec = status & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; dir_q  <= '0; dout_q <= '0; mask_q <= '0;
      pol_q  <= '0; trig_q <= '0; filt_q <= '0; both_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_MODE:   mode_q <= wdata_n;
        SEL_DIR:    dir_q  <= wdata_n;
        SEL_DOUT:   dout_q <= wdata_n;
        SEL_MASK:   mask_q <= mask_q & wdata_n;
        SEL_UNMASK: mask_q <= mask_q | wdata_n;
        SEL_POL:    pol_q  <= wdata_n;
        SEL_TRIG:   trig_q <= wdata_n;
        SEL_FILT:   filt_q <= wdata_n;
        SEL_BOTH:   both_q <= wdata_n;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_req) | evt_set;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_wr) begin
      case (sel)
        SEL_MODE: bus_rdata[N-1:0] = mode_q;
        SEL_DIR:  bus_rdata[N-1:0] = dir_q;
        SEL_DOUT: bus_rdata[N-1:0] = dout_q;
        SEL_DIN:  bus_rdata[N-1:0] = (dir_q & dout_q) | (~dir_q & line_sync);
        SEL_STAT: bus_rdata[N-1:0] = status;
        SEL_MASK: bus_rdata[N-1:0] = mask_q;
        SEL_POL:  bus_rdata[N-1:0] = pol_q;
        SEL_TRIG: bus_rdata[N-1:0] = trig_q;
        SEL_FILT: bus_rdata[N-1:0] = filt_q;
        SEL_BOTH: bus_rdata[N-1:0] = both_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pin_o  = dout_q;
  assign pin_oe = dir_q & ~mode_q;
  assign irq_o  = |irq_vec;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned NLINES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_clr,
  input logic              wr_mask,
  input logic              wr_unmask,
  input logic [NLINES-1:0] wdata,
  input logic [NLINES-1:0] pend,
  input logic [NLINES-1:0] mask,
  input logic [NLINES-1:0] evt_set,
  input logic              irq_o
);
  a_r5_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(evt_set)) == $past(evt_set)));

  a_r7_clear_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pend & $past(wdata) & ~$past(evt_set)) == '0));

  a_r7_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> (($past(pend) & ~pend) == '0));

  a_r8_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> ((mask & ~$past(wdata)) == '0));

  a_r8_unmask_on: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> ((mask & $past(wdata)) == $past(wdata)));

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_clr(wr_clr), .wr_mask(wr_mask),
  .wr_unmask(wr_unmask), .wdata(wdata_n), .pend(pend_q), .mask(mask_q),
  .evt_set(evt_set), .irq_o(irq_o)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_i = '0, pin_o, pin_oe;
  logic        irq_o;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.NLINES(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_reset();
    logic [7:0] addrs [12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                               8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h4C};
    do_reset();
    for (int i = 0; i < 12; i++) rdchk("R1 reg", addrs[i], 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_o", pin_o, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_output();
    do_reset();
    wr(8'h04, 32'h0000_00FF);
    wr(8'h08, 32'hA5A5_A5A5);
    pin_i = 32'h1234_5600;
    settle();
    chk("R2 oe", pin_oe, 32'h0000_00FF);
    chk("R2 out", pin_o, 32'hA5A5_A5A5);
    rdchk("R3 din mixed", 8'h0C, 32'h1234_56A5);
    wr(8'h00, 32'h0000_0001);
    chk("R2 irq line no drive", pin_oe, 32'h0000_00FE);
  endtask

  task automatic t_level();
    do_reset();
    wr(8'h00, 32'h30);
    wr(8'h20, 32'h20);
    wr(8'h1C, 32'h30);
    settle();
    rdchk("R4 active low idle", 8'h10, 32'h20);
    chk("R9 irq level", {31'h0, irq_o}, 32'h1);
    pin_i = 32'h10; settle();
    rdchk("R4 both active", 8'h10, 32'h30);
    pin_i = 32'h30; settle();
    rdchk("R4 low released", 8'h10, 32'h10);
    pin_i = 32'h20; settle();
    rdchk("R4 not latched", 8'h10, 32'h00);
    chk("R9 irq drops", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_edge();
    do_reset();
    wr(8'h00, 32'h700);
    wr(8'h24, 32'h700);
    wr(8'h20, 32'h600);
    wr(8'h4C, 32'h400);
    settle();
    rdchk("R5 idle", 8'h10, 32'h0);
    pin_i = 32'h100; settle();
    rdchk("R5 rising", 8'h10, 32'h100);
    pin_i = 32'h000; settle();
    rdchk("R5 latched", 8'h10, 32'h100);
    pin_i = 32'h200; settle();
    rdchk("R5 falling ignores rise", 8'h10, 32'h100);
    pin_i = 32'h000; settle();
    rdchk("R5 falling", 8'h10, 32'h300);
    pin_i = 32'h400; settle();
    rdchk("R6 both rise", 8'h10, 32'h700);
    chk("R8 masked irq", {31'h0, irq_o}, 32'h0);
    wr(8'h14, 32'h0); settle();
    rdchk("R7 zero write", 8'h10, 32'h700);
    wr(8'h14, 32'h400); settle();
    rdchk("R7 clear one", 8'h10, 32'h300);
    pin_i = 32'h000; settle();
    rdchk("R6 both fall", 8'h10, 32'h700);
    wr(8'h14, 32'h700); settle();
    rdchk("R7 clear all", 8'h10, 32'h0);
  endtask

  task automatic t_mask();
    // continues from t_edge: lines 8..10 configured, nothing pending
    pin_i = 32'h100; settle();
    rdchk("R5 pending again", 8'h10, 32'h100);
    wr(8'h1C, 32'h0);
    chk("R8 unmask zero", {31'h0, irq_o}, 32'h0);
    wr(8'h1C, 32'h100);
    chk("R9 irq on", {31'h0, irq_o}, 32'h1);
    rdchk("R8 mask read", 8'h18, 32'h100);
    wr(8'h18, 32'hFFFF_FFFF);
    chk("R8 mask ones no effect", {31'h0, irq_o}, 32'h1);
    wr(8'h18, ~32'h100);
    chk("R8 masked off", {31'h0, irq_o}, 32'h0);
    rdchk("R8 mask zero", 8'h18, 32'h0);
    rdchk("R8 clr reads 0", 8'h14, 32'h0);
    rdchk("R8 unmask reads 0", 8'h1C, 32'h0);
  endtask

  task automatic t_regs();
    do_reset();
    wr(8'h20, 32'h1111_1111);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h28, 32'h3333_3333);
    wr(8'h4C, 32'h4444_4444);
    rdchk("R10 pol", 8'h20, 32'h1111_1111);
    rdchk("R10 trig", 8'h24, 32'hFFFF_FFFF);
    rdchk("R10 filt", 8'h28, 32'h3333_3333);
    rdchk("R10 both", 8'h4C, 32'h4444_4444);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rdchk("R10 dout untouched", 8'h08, 32'h0);
    rdchk("R10 undecoded", 8'h30, 32'h0);
    wr(8'h1C, 32'hFFFF_FFFF);
    pin_i = 32'hFFFF_0000; settle();
    pin_i = 32'h0000_FFFF; settle();
    rdchk("R11 general lines no status", 8'h10, 32'h0);
    chk("R11 no irq", {31'h0, irq_o}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_output();
    t_level();
    t_edge();
    t_mask();
    t_regs();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule